// File: doc/BRIEF.md
# Multi-Subschedule Egress Gate Scheduler

This block opens and closes the egress traffic-class queues of a small switch on a fixed timetable. All timeslots live in one linear slot table. Up to eight execution threads, called subschedules, run at the same time. Each thread cycles through its own contiguous slice of that table. A thread holds each slot for a programmed number of ticks, moves to the next slot, and returns to the first slot of its slice after its last one. Every slot names the ports it applies to and, optionally, a set of queues to close on those ports. The result is a gate vector with eight bits for each of five ports.

Software loads the tables while the scheduler is stopped, through a single write port. One register selector picks the target: the slot table, a thread's entry record, a thread's end index, the global control word, or the base time. Raising `sched_en` starts the local tick counter from zero. Each thread then starts on its own once the counter reaches the base time plus that thread's start offset. A prescaler turns `CLKS_PER_TICK` clock cycles into one tick. The default of 10 cycles at 50 MHz gives a 200 ns tick.

Top module: `tsn_gate_sched`

## Requirements
- R1: After reset, while `sched_en` is low, and while the clock-source field (global word bits [1:0]) holds any value other than 1 (0 = off, 2 and 3 = external sources, which are not supported), every gate bit is 1 (open).
- R2: While a running thread's current slot covers port p (slot bits [22:18] give the port mask) and its mask-enable bit [23] is set, gate byte `gates_o[8p+7:8p]` equals the inverse of the closed-queue mask in slot bits [31:24]. A set mask bit closes that queue and drives its gate bit to 0.
- R3: A port that no running thread's current slot covers, or that is covered by a slot whose mask-enable bit is clear, has all eight gates open.
- R4: Each slot stays in force for its hold value (slot bits [17:0]) in ticks of `CLKS_PER_TICK` clock cycles. The following slot then takes over.
- R5: After a thread executes the slot at its end index (end-index word bits [9:0], thread number on `cfg_addr`), it continues at its start address. Slots outside its slice are never used.
- R6: A thread starts only when the tick counter is greater than or equal to the base time plus its start offset (entry record bits [17:0]). Until it starts, the ports it would cover stay open.
- R7: Only threads numbered 0 through the active-count field (global word bits [4:2]) run. A thread with a higher number stays idle even if its entry record is loaded.
- R8: If two running threads cover the same port, the lower-numbered thread sets that port's gates.
- R9: Writes are ignored while `sched_en` is high. This holds for the slot table and for the global word.
- R10: An entry record goes to the thread named in its own bits [30:28], and `cfg_addr` is ignored for that record. Its start address is in bits [27:18].
- R11: When `sched_en` rises again, the tick counter restarts at zero and every thread starts over from its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sched_en | input | 1 | Runs the scheduler when high; configuration writes are accepted only when low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0 slot, 1 entry record, 2 end index, 3 global word, 4 base time |
| cfg_addr | input | 10 | Slot address, or thread number for an end-index write |
| cfg_wdata | input | 32 | Write data, laid out as the requirements give |
| gates_o | output | 40 | Gate bits, one byte per port, port 0 in the low byte; 1 = open |

## Verification
The hardest case to reach from the ports is two threads that overlap on one port while each also owns a port of its own. The overlap must be in force while a thread at a higher number than the active count sits fully loaded but idle. The stimulus builds this directly. It uses a base time above zero and staggered start offsets, so the start of each thread is seen on its own. A third entry record points at a slot that would close every queue on a port nothing else uses. Samples fall in the middle of ticks on either side of each start time, so one tick of error in a start or a slot length shows up. The same run then rewrites the tables while the scheduler is enabled. It also cycles through the unsupported clock sources before a final restart.

// File: rtl/tsn_gate_pkg.sv
// Shared field layouts for the egress gate scheduler.
// Assumes the 32-bit slot word layout is fixed; the port-mask field is
// PORT_FIELD_W wide and the queue-mask field TC_NUM wide.
package tsn_gate_pkg;

    localparam int HOLD_W       = 18;
    localparam int PORT_FIELD_W = 5;
    localparam int TC_NUM       = 8;
    localparam int CFG_SEL_W    = 3;
    localparam int CFG_DATA_W   = 32;
    localparam int EP_ADDR_LSB  = 18;
    localparam int EP_THR_LSB   = 28;
    localparam int ACT_LSB      = 2;

    typedef enum logic [CFG_SEL_W-1:0] {
        SEL_SLOT   = 3'd0,
        SEL_ENTRY  = 3'd1,
        SEL_END    = 3'd2,
        SEL_GLOBAL = 3'd3,
        SEL_BASE   = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_EXT_A = 2'd2,
        SRC_EXT_B = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [TC_NUM-1:0]       closed;
        logic                    mask_en;
        logic [PORT_FIELD_W-1:0] ports;
        logic [HOLD_W-1:0]       hold;
    } slot_t;

endpackage

// File: rtl/tsn_gate_tick.sv
// Tick generator: divides the clock by CLKS_PER_TICK and counts ticks.
// Assumes run is low or restart is pulsed before a new schedule run; both
// return the prescaler and the tick count to zero.
module tsn_gate_tick #(
    parameter int CLKS_PER_TICK = 10,
    parameter int TIME_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    output logic              tick_stb,
    output logic [TIME_W-1:0] tick_cnt
);
    localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick_stb = run && (pre_q == PRE_LAST);

    // Advance the prescaler and bump the tick count at each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q    <= '0;
            tick_cnt <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q    <= '0;
            tick_cnt <= tick_cnt + 1'b1;
        end else begin
            pre_q    <= pre_q + 1'b1;
        end
    end

    // R11
    tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tick_cnt == '0));

endmodule

// File: rtl/tsn_gate_thread.sv
// One subschedule thread: waits for its start time, then walks its slice of
// the slot table, holding each slot for its tick count and wrapping from the
// end index to the start address. Assumes the configuration is stable while
// go is high. The current slot is latched, so one table read port is enough.
module tsn_gate_thread
    import tsn_gate_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick_stb,
    input  logic [TIME_W-1:0] tick_cnt,
    input  logic [TIME_W:0]   start_time,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  slot_t             rd_entry,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              running,
    output slot_t             cur
);
    logic [ADDR_W-1:0] idx_q;
    logic [HOLD_W-1:0] remain_q;
    logic [ADDR_W-1:0] next_idx;
    logic [HOLD_W-1:0] load_hold;
    logic              due;

    // Select the slot that follows the current one inside the slice.
    always_comb begin
        if (idx_q >= end_addr) next_idx = start_addr;
        else                   next_idx = idx_q + 1'b1;
    end

    assign rd_addr   = running ? next_idx : start_addr;
    assign load_hold = (rd_entry.hold == '0) ? HOLD_W'(1) : rd_entry.hold;
    assign due       = ({1'b0, tick_cnt} >= start_time);

    // Start the thread at its due time, then count down and advance slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            idx_q    <= '0;
            remain_q <= '0;
            cur      <= '0;
        end else if (!go) begin
            running  <= 1'b0;
        end else if (!running) begin
            if (due) begin
                running  <= 1'b1;
                idx_q    <= start_addr;
                cur      <= rd_entry;
                remain_q <= load_hold;
            end
        end else if (tick_stb) begin
            if (remain_q <= HOLD_W'(1)) begin
                idx_q    <= next_idx;
                cur      <= rd_entry;
                remain_q <= load_hold;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && running && tick_stb && (remain_q > HOLD_W'(1)))
            |=> (remain_q == $past(remain_q) - 1'b1));

    // R5
    slice_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (start_addr <= end_addr))
            |-> ((idx_q >= start_addr) && (idx_q <= end_addr)));

    // R6
    start_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past({1'b0, tick_cnt} >= start_time));

endmodule

// File: rtl/tsn_gate_merge.sv
// Gate merge: for every port, finds the lowest-numbered running thread whose
// current slot covers the port and turns that slot's closed-queue mask into
// open gate bits. A port that no thread covers, or that a slot with its mask
// disabled covers, stays fully open. Purely combinational.
module tsn_gate_merge
    import tsn_gate_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int NUM_PORTS   = 5
) (
    input  logic [NUM_THREADS-1:0]        running,
    input  slot_t [NUM_THREADS-1:0]       cur,
    output logic [NUM_PORTS*TC_NUM-1:0]   gates
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [TC_NUM-1:0] byte_open;

        // Scan from the highest thread down so the lowest-numbered one wins.
        always_comb begin
            byte_open = '1;
            for (int i = NUM_THREADS - 1; i >= 0; i--) begin
                if (running[i] && cur[i].ports[p]) begin
                    byte_open = cur[i].mask_en ? ~cur[i].closed : '1;
                end
            end
        end

        assign gates[p*TC_NUM +: TC_NUM] = byte_open;
    end

endmodule

// File: rtl/tsn_gate_sched.sv
// Egress gate scheduler top: holds the slot table, the per-thread entry and
// end registers and the global control, runs the tick generator, one thread
// per subschedule and the gate merge, and registers the gate vector.
// Assumes TBL_DEPTH is a power of two no larger than 1024, NUM_PORTS is at
// most the port-mask width, and that software writes only while stopped.
module tsn_gate_sched
    import tsn_gate_pkg::*;
#(
    parameter int NUM_THREADS   = 8,
    parameter int TBL_DEPTH     = 1024,
    parameter int CLKS_PER_TICK = 10,
    parameter int TIME_W        = 32,
    parameter int NUM_PORTS     = 5,
    localparam int ADDR_W       = $clog2(TBL_DEPTH),
    localparam int GATE_W       = NUM_PORTS * TC_NUM
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sched_en,
    input  logic                  cfg_we,
    input  logic [CFG_SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [GATE_W-1:0]     gates_o
);
    localparam int THR_W = $clog2(NUM_THREADS);

    slot_t             slot_tbl [TBL_DEPTH];
    logic [HOLD_W-1:0] ep_off_q  [NUM_THREADS];
    logic [ADDR_W-1:0] ep_addr_q [NUM_THREADS];
    logic [ADDR_W-1:0] end_q     [NUM_THREADS];
    clk_src_e          clk_src_q;
    logic [THR_W-1:0]  act_cnt_q;
    logic [TIME_W-1:0] base_q;

    logic                   cfg_ok;
    cfg_sel_e               sel;
    logic [THR_W-1:0]       wr_thr;
    logic                   run_now;
    logic                   run_q;
    logic                   tick_stb;
    logic [TIME_W-1:0]      tick_cnt;
    logic [NUM_THREADS-1:0] active_mask;
    logic [NUM_THREADS-1:0] running_vec;
    slot_t [NUM_THREADS-1:0] cur_vec;
    logic [GATE_W-1:0]      merged;

    assign cfg_ok  = cfg_we && !sched_en;
    assign sel     = cfg_sel_e'(cfg_sel);
    assign wr_thr  = cfg_wdata[EP_THR_LSB +: THR_W];
    assign run_now = sched_en && (clk_src_q == SRC_LOCAL);

    // Store slot words; the table is left without reset.
    always_ff @(posedge clk) begin
        if (cfg_ok && (sel == SEL_SLOT)) begin
            slot_tbl[cfg_addr] <= slot_t'(cfg_wdata);
        end
    end

    // Store entry records, end indices, the global word and the base time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                ep_off_q[t]  <= '0;
                ep_addr_q[t] <= '0;
                end_q[t]     <= '0;
            end
            clk_src_q <= SRC_OFF;
            act_cnt_q <= '0;
            base_q    <= '0;
        end else if (cfg_ok) begin
            case (sel)
                SEL_ENTRY: begin
                    ep_off_q[wr_thr]  <= cfg_wdata[HOLD_W-1:0];
                    ep_addr_q[wr_thr] <= cfg_wdata[EP_ADDR_LSB +: ADDR_W];
                end
                SEL_END:    end_q[cfg_addr[THR_W-1:0]] <= cfg_wdata[ADDR_W-1:0];
                SEL_GLOBAL: begin
                    clk_src_q <= clk_src_e'(cfg_wdata[1:0]);
                    act_cnt_q <= cfg_wdata[ACT_LSB +: THR_W];
                end
                SEL_BASE:   base_q <= cfg_wdata[TIME_W-1:0];
                default: ;
            endcase
        end
    end

    // Remember the previous run state to find the starting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_now;
    end

    tsn_gate_tick #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .TIME_W        (TIME_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_now),
        .restart  (run_now && !run_q),
        .tick_stb (tick_stb),
        .tick_cnt (tick_cnt)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [ADDR_W-1:0] rd_addr;
        slot_t             rd_entry;
        logic [TIME_W:0]   start_time;

        assign active_mask[t] = (t <= int'(act_cnt_q));
        assign start_time     = {1'b0, base_q} + (TIME_W + 1)'(ep_off_q[t]);
        assign rd_entry       = slot_tbl[rd_addr];

        tsn_gate_thread #(
            .ADDR_W (ADDR_W),
            .TIME_W (TIME_W)
        ) u_thread (
            .clk        (clk),
            .rst_n      (rst_n),
            .go         (run_now && run_q && active_mask[t]),
            .tick_stb   (tick_stb),
            .tick_cnt   (tick_cnt),
            .start_time (start_time),
            .start_addr (ep_addr_q[t]),
            .end_addr   (end_q[t]),
            .rd_entry   (rd_entry),
            .rd_addr    (rd_addr),
            .running    (running_vec[t]),
            .cur        (cur_vec[t])
        );
    end

    tsn_gate_merge #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_PORTS   (NUM_PORTS)
    ) u_merge (
        .running (running_vec),
        .cur     (cur_vec),
        .gates   (merged)
    );

    // Register the gate vector; everything opens while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)       gates_o <= '1;
        else if (run_now) gates_o <= merged;
        else              gates_o <= '1;
    end

    // R1
    off_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_now |=> (gates_o == '1));

    // R7
    inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_vec & ~active_mask) == '0);

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_en |=> ($stable(base_q) && $stable(act_cnt_q) && $stable(clk_src_q)));

endmodule

// File: tb/tsn_gate_sched_tb.sv
module tsn_gate_sched_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sched_en;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [9:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [39:0] gates_o;

    int errors = 0;
    int checks = 0;
    int cur    = 0;

    always #10 clk = ~clk;

    tsn_gate_sched u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sched_en  (sched_en),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .gates_o   (gates_o)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input string req, input int p, input logic [7:0] exp);
        logic [7:0] act;
        act = gates_o[p*8 +: 8];
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port%0d at cycle %0d: actual %h expected %h",
                     req, p, cur, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [9:0] addr, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cur++;
    endtask

    task automatic wr_slot(input int a, input int hold, input logic [4:0] ports,
                           input logic en, input logic [7:0] closed);
        wr(3'd0, 10'(a), {closed, en, ports, 18'(hold)});
    endtask

    task automatic wr_entry(input int addr_junk, input int thr, input int start, input int off);
        wr(3'd1, 10'(addr_junk), {1'b0, 3'(thr), 10'(start), 18'(off)});
    endtask

    task automatic wr_glob(input int act, input int src);
        wr(3'd3, 10'd0, {27'd0, 3'(act), 2'(src)});
    endtask

    task automatic start_run();
        sched_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cur = 0;
    endtask

    task automatic stop_run();
        sched_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic go_to(input int c);
        while (cur < c) begin
            @(negedge clk);
            cur++;
        end
    endtask

    task automatic all_open(input string req);
        for (int p = 0; p < 5; p++) chk(req, p, 8'hFF);
    endtask

    // Reset state: all gates open.
    task automatic t_reset();
        all_open("R1 reset");
        wr_glob(0, 1);
        repeat (30) @(negedge clk);
        all_open("R1 sched_en low");
    endtask

    // One thread, three slots: masks, hold times, wrap and restart.
    task automatic t_single();
        wr_slot(0, 2, 5'b00011, 1'b1, 8'h0F);
        wr_slot(1, 3, 5'b00100, 1'b1, 8'hAA);
        wr_slot(2, 1, 5'b11111, 1'b0, 8'h33);
        wr_slot(3, 1, 5'b11111, 1'b1, 8'h00);
        wr_entry(0, 0, 0, 0);
        wr(3'd2, 10'd0, 32'd2);
        wr(3'd4, 10'd0, 32'd0);
        wr_glob(0, 1);
        start_run();
        go_to(5);
        chk("R2 slot0", 0, 8'hF0);
        chk("R2 slot0", 1, 8'hF0);
        chk("R3 uncovered", 2, 8'hFF);
        go_to(15);
        chk("R4 slot0 second tick", 0, 8'hF0);
        go_to(25);
        chk("R4 slot1", 2, 8'h55);
        chk("R3 uncovered", 0, 8'hFF);
        go_to(49);
        chk("R4 slot1 last tick", 2, 8'h55);
        go_to(55);
        chk("R3 mask disabled", 0, 8'hFF);
        chk("R3 mask disabled", 2, 8'hFF);
        go_to(65);
        chk("R5 wrap to start", 0, 8'hF0);
        chk("R5 slot3 unused", 3, 8'hFF);
        go_to(85);
        chk("R5 second lap slot1", 2, 8'h55);
        stop_run();
        all_open("R1 stopped");
        start_run();
        go_to(5);
        chk("R11 restart from start", 0, 8'hF0);
        chk("R11 restart from start", 2, 8'hFF);
    endtask

    // Two staggered threads, an overlap and a loaded idle thread.
    task automatic t_multi();
        stop_run();
        wr_slot(10, 4, 5'b00001, 1'b1, 8'h01);
        wr_slot(20, 4, 5'b00011, 1'b1, 8'h80);
        wr_slot(30, 4, 5'b01000, 1'b1, 8'hFF);
        wr_entry(0, 0, 10, 0);
        wr_entry(5, 1, 20, 2);
        wr_entry(6, 2, 30, 0);
        wr(3'd2, 10'd0, 32'd10);
        for (int t = 1; t < 8; t++) wr(3'd2, 10'(t), 32'd20);
        wr(3'd4, 10'd0, 32'd3);
        wr_glob(1, 1);
        start_run();
        go_to(20);
        chk("R6 before base", 0, 8'hFF);
        go_to(40);
        chk("R6 thread0 started", 0, 8'hFE);
        chk("R6 thread1 not yet", 1, 8'hFF);
        chk("R7 thread2 idle", 3, 8'hFF);
        go_to(45);
        chk("R6 thread1 not yet", 1, 8'hFF);
        go_to(60);
        chk("R8 lower thread wins", 0, 8'hFE);
        chk("R10 record routed by field", 1, 8'h7F);
        chk("R7 thread2 idle", 3, 8'hFF);
        go_to(100);
        wr_slot(10, 4, 5'b00001, 1'b1, 8'h00);
        wr_glob(1, 0);
        go_to(150);
        chk("R9 slot write ignored", 0, 8'hFE);
        chk("R9 global write ignored", 1, 8'h7F);
    endtask

    // Unsupported and disabled clock sources keep everything open.
    task automatic t_clksrc();
        for (int s = 0; s < 4; s++) begin
            if (s == 1) continue;
            stop_run();
            wr_glob(1, s);
            start_run();
            go_to(70);
            chk($sformatf("R1 clock source %0d", s), 0, 8'hFF);
            chk($sformatf("R1 clock source %0d", s), 1, 8'hFF);
        end
        stop_run();
        wr_glob(1, 1);
        start_run();
        go_to(20);
        chk("R11 tick count restarted", 0, 8'hFF);
        go_to(70);
        chk("R8 after restart", 0, 8'hFE);
        chk("R11 after restart", 1, 8'h7F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sched_en = 1'b0; cfg_we = 1'b0;
        cfg_sel = '0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_clksrc();
        summary();
        $finish;
    end

endmodule